// File: doc/BRIEF.md
# Two-Level Serial-Port Interrupt Collector

This block collects the interrupt events of a serial-port controller into a two-tier register set and drives one interrupt request line. Three detail registers hold the less frequent causes: a line-condition register, a matched-character register and a general-status register. A top-level register holds five direct event flags in its upper bits. Its three low bits each report that one detail register has a pending bit that is enabled. Every one of the four source registers has its own 8-bit enable mask. A masked bit still shows in its register but cannot raise the request.

The detail registers do not all clear the same way. The matched-character and general-status registers latch pulses and clear when the host reads them. The line-condition register is a registered copy of its level inputs, and a read does not change it. The top-level register clears on a read. Any bit whose set condition is present in the same cycle as the read stays set, so no event is lost. The host uses a synchronous read port with a strobe and address, and read data appears one cycle later. It sets the four enable masks through a matching write port and can read them back.

Register addresses, which are fixed by the read and write decode: 0 top-level, 1 line-condition, 2 matched-character, 3 general-status, 4 top-level enable, 5 line-condition enable, 6 matched-character enable, 7 general-status enable. Writes to addresses 0 to 3 are ignored.

Top module: `uirq_collector`

## Requirements
- R1: While reset is held and just after it is released, every source register and every enable register reads 0, `irq_n` is 1 and `rd_data` is 0.
- R2: A write at address 4 to 7 loads `wr_data` into that enable mask. A read whose strobe is sampled on clock edge k shows the addressed register's value from before edge k on `rd_data` right after edge k. `rd_data` holds its value while no read is made.
- R3: A pulse on bit i of `spc_evt` (or `sts_evt`) sets bit i of register 2 (or 3) after the edge on which it is sampled. The bit holds until that register is read, and the read returns it and clears it to 0.
- R4: When an event bit of register 2, register 3 or the top-level register arrives in the same cycle as a read of that register, the read returns the value from before the event, and the bit is set after the read.
- R5: Register 1 equals `line_cond` as sampled on the previous edge. Reading register 1 does not change it.
- R6: Top-level bit 0, 1 or 2 becomes set one edge after register 1, 2 or 3 holds a bit that is also set in that register's enable mask (addresses 5, 6, 7). Detail bits that are masked do not set the summary bit.
- R7: A pulse on `top_evt[j]` sets top-level bit j+3 after the edge on which it is sampled.
- R8: A read of the top-level register clears all its bits, except bits whose set condition (R6, R7) holds in that same cycle.
- R9: `irq_n` is 0 exactly when some top-level bit is set whose bit in the top-level enable mask (address 4) is also set. It is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, valid one cycle after the strobe |
| wr_en | input | 1 | Write strobe for the enable masks |
| wr_addr | input | 3 | Write register address (4 to 7 take effect) |
| wr_data | input | 8 | Write data |
| top_evt | input | 5 | Direct top-level event pulses, bit j sets top-level bit j+3 |
| line_cond | input | 8 | Line-condition levels |
| spc_evt | input | 8 | Matched-character event pulses |
| sts_evt | input | 8 | General-status event pulses |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The case that needs the most care is a clear-on-read and a new event on the same register in the same cycle. It occurs for registers 2 and 3 and for the top-level register, where a summary bit or a direct pulse can arrive in the cycle of the read. Directed phases line up an event pulse with a read strobe to the same address. A long random phase then produces many such coincidences by chance. Each cycle, a bench model built from the requirements judges two things: that the read returned the value from before the event, and that the bit is still set afterwards and keeps `irq_n` low when it is enabled.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    parameter int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_TOP     = 3'd0;
    localparam logic [ADDR_W-1:0] A_LINE    = 3'd1;
    localparam logic [ADDR_W-1:0] A_SPC     = 3'd2;
    localparam logic [ADDR_W-1:0] A_STS     = 3'd3;
    localparam logic [ADDR_W-1:0] A_TOP_EN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LINE_EN = 3'd5;
    localparam logic [ADDR_W-1:0] A_SPC_EN  = 3'd6;
    localparam logic [ADDR_W-1:0] A_STS_EN  = 3'd7;
    localparam int NUM_SRC = 4;
    localparam int NUM_DETAIL = 3;
endpackage

// File: rtl/uirq_cor_reg.sv
module uirq_cor_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) s_d.bits = '0;
        s_d.bits = s_d.bits | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.bits;

    AST_COR_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((q & $past(evt)) == $past(evt))); // R4
    AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> (q == '0)); // R3
    AST_COR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((q & $past(q)) == $past(q))); // R3
endmodule

// File: rtl/uirq_level_reg.sv
module uirq_level_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.bits = cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.bits;
endmodule

// File: rtl/uirq_top_reg.sv
module uirq_top_reg #(
    parameter int W    = 8,
    parameter int NSUM = 3,
    localparam int EVW = W - NSUM
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EVW-1:0]  evt,
    input  logic [NSUM-1:0] pend,
    input  logic            clr,
    input  logic [W-1:0]    en,
    output logic [W-1:0]    q,
    output logic            irq_n
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) s_d.bits = '0;
        s_d.bits = s_d.bits | {evt, pend};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q     = s_q.bits;
    assign irq_n = ~|(s_q.bits & en);

    AST_TOP_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((q[W-1:NSUM] & $past(evt)) == $past(evt))); // R7
    AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |=> ((q[NSUM-1:0] & $past(pend)) == $past(pend))); // R6
    AST_TOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0 && pend == '0) |=> (q == '0)); // R8
endmodule

// File: rtl/uirq_collector.sv
module uirq_collector
    import uirq_pkg::*;
#(
    parameter int DW = 8,
    localparam int NSUM = NUM_DETAIL,
    localparam int EVW  = DW - NSUM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [EVW-1:0]    top_evt,
    input  logic [DW-1:0]     line_cond,
    input  logic [DW-1:0]     spc_evt,
    input  logic [DW-1:0]     sts_evt,
    output logic              irq_n
);
    localparam int NCOR = 2;

    typedef struct packed {
        logic [NUM_SRC-1:0][DW-1:0] en;
        logic [DW-1:0]              rdata;
    } state_t;

    state_t s_d, s_q;

    logic [DW-1:0]            top_q;
    logic [DW-1:0]            line_q;
    logic [NCOR-1:0][DW-1:0]  cor_evt;
    logic [NCOR-1:0][DW-1:0]  cor_q;
    logic [NCOR-1:0]          cor_clr;
    logic [NSUM-1:0]          pend;

    assign cor_evt[0] = spc_evt;
    assign cor_evt[1] = sts_evt;
    assign cor_clr[0] = rd_en && (rd_addr == A_SPC);
    assign cor_clr[1] = rd_en && (rd_addr == A_STS);

    uirq_level_reg #(.W(DW)) i_line (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (line_cond),
        .q     (line_q)
    );

    for (genvar g = 0; g < NCOR; g++) begin : g_cor
        uirq_cor_reg #(.W(DW)) i_cor (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (cor_evt[g]),
            .clr   (cor_clr[g]),
            .q     (cor_q[g])
        );
    end

    assign pend[0] = |(line_q & s_q.en[1]);
    for (genvar g = 0; g < NCOR; g++) begin : g_pend
        assign pend[g+1] = |(cor_q[g] & s_q.en[g+2]);
    end

    uirq_top_reg #(.W(DW), .NSUM(NSUM)) i_top (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (top_evt),
        .pend  (pend),
        .clr   (rd_en && (rd_addr == A_TOP)),
        .en    (s_q.en[0]),
        .q     (top_q),
        .irq_n (irq_n)
    );

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            case (rd_addr)
                A_TOP:   s_d.rdata = top_q;
                A_LINE:  s_d.rdata = line_q;
                A_SPC:   s_d.rdata = cor_q[0];
                A_STS:   s_d.rdata = cor_q[1];
                default: s_d.rdata = s_q.en[rd_addr[1:0]];
            endcase
        end
        if (wr_en && wr_addr[ADDR_W-1]) begin
            s_d.en[wr_addr[1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rd_data)); // R2
    AST_LINE_IGNORES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_LINE) |=> (line_q == $past(line_cond))); // R5
    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (((top_evt & s_q.en[0][DW-1:NSUM]) != '0) && !(wr_en && wr_addr == A_TOP_EN))
        |=> !irq_n); // R9
endmodule

// File: tb/test_uirq_collector.sv
`timescale 1ns/1ps
module test_uirq_collector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] top_evt = '0;
    logic [7:0] line_cond = '0;
    logic [7:0] spc_evt = '0;
    logic [7:0] sts_evt = '0;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] m_top = '0, m_line = '0, m_spc = '0, m_sts = '0, m_rdata = '0;
    logic [7:0] m_en [4] = '{default: 8'h00};

    always #2.5 clk = ~clk;

    uirq_collector i_uirq_collector (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .top_evt(top_evt),
        .line_cond(line_cond), .spc_evt(spc_evt), .sts_evt(sts_evt), .irq_n(irq_n)
    );

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_top;
            3'd1: return m_line;
            3'd2: return m_spc;
            3'd3: return m_sts;
            default: return m_en[a[1:0]];
        endcase
    endfunction

    function automatic logic model_irq_n();
        return ~|(m_top & m_en[0]);
    endfunction

    task automatic step(input string tag);
        logic [2:0] sum;
        @(posedge clk);
        sum = {|(m_sts & m_en[3]), |(m_spc & m_en[2]), |(m_line & m_en[1])};
        if (rd_en) m_rdata = model_read(rd_addr);
        m_top = (((rd_en && rd_addr == 3'd0) ? 8'h00 : m_top) | {top_evt, sum});
        m_spc = (((rd_en && rd_addr == 3'd2) ? 8'h00 : m_spc) | spc_evt);
        m_sts = (((rd_en && rd_addr == 3'd3) ? 8'h00 : m_sts) | sts_evt);
        m_line = line_cond;
        if (wr_en && wr_addr[2]) m_en[wr_addr[1:0]] = wr_data;
        @(negedge clk);
        check(tag, "irq_n", {7'b0, irq_n}, {7'b0, model_irq_n()});
        check(tag, "rd_data", rd_data, m_rdata);
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; top_evt = '0; spc_evt = '0; sts_evt = '0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        rd_en = 1; rd_addr = a;
        step(tag);
        rd_en = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v, input string tag);
        wr_en = 1; wr_addr = a; wr_data = v;
        step(tag);
        wr_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", "irq_n in reset", {7'b0, irq_n}, 8'h01);
        check("R1", "rd_data in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(a[2:0], "R1");

        // R2: enable masks write and read back
        wr(3'd4, 8'hA5, "R2"); wr(3'd5, 8'h3C, "R2");
        wr(3'd6, 8'h81, "R2"); wr(3'd7, 8'h7E, "R2");
        wr(3'd1, 8'hFF, "R2");
        for (int a = 0; a < 8; a++) rd(a[2:0], "R2");
        step("R2"); step("R2");
        for (int a = 4; a < 8; a++) wr(a[2:0], 8'h00, "R2");

        // R3: clear-on-read of matched-character and status registers
        spc_evt = 8'h12; step("R3"); idle();
        spc_evt = 8'h40; step("R3"); idle();
        sts_evt = 8'h81; step("R3"); idle();
        step("R3");
        rd(3'd2, "R3"); rd(3'd2, "R3");
        rd(3'd3, "R3"); rd(3'd3, "R3");

        // R4: event coincident with clear-on-read
        spc_evt = 8'h05; step("R4"); idle();
        spc_evt = 8'h20; rd(3'd2, "R4"); idle();
        rd(3'd2, "R4");
        sts_evt = 8'h0F; rd(3'd3, "R4"); idle();
        rd(3'd3, "R4");
        top_evt = 5'h01; step("R4"); idle();
        top_evt = 5'h10; rd(3'd0, "R4"); idle();
        rd(3'd0, "R4");

        // R5: line register follows its level, reads have no effect
        line_cond = 8'h09; step("R5");
        rd(3'd1, "R5"); rd(3'd1, "R5");
        line_cond = 8'h00; step("R5"); rd(3'd1, "R5");

        // R6: summary bits with masked and enabled detail bits
        wr(3'd5, 8'h01, "R6"); wr(3'd6, 8'h80, "R6"); wr(3'd7, 8'h02, "R6");
        line_cond = 8'h02; spc_evt = 8'h7F; sts_evt = 8'h01; step("R6"); idle();
        step("R6"); rd(3'd0, "R6");
        line_cond = 8'h01; spc_evt = 8'h80; sts_evt = 8'h02; step("R6"); idle();
        step("R6"); step("R6"); rd(3'd0, "R6");
        rd(3'd2, "R6"); rd(3'd3, "R6");
        line_cond = 8'h00; step("R6"); step("R6");
        rd(3'd0, "R6"); rd(3'd0, "R6");

        // R7 / R8: direct events and top-level clear
        top_evt = 5'h15; step("R7"); idle(); rd(3'd0, "R7");
        top_evt = 5'h0A; step("R8"); idle(); rd(3'd0, "R8"); rd(3'd0, "R8");

        // R9: top-level mask
        wr(3'd4, 8'h08, "R9");
        top_evt = 5'h02; step("R9"); idle(); step("R9");
        top_evt = 5'h01; step("R9"); idle(); step("R9");
        rd(3'd0, "R9"); step("R9");
        wr(3'd4, 8'h00, "R9");

        // Random mix, all requirements judged by the model (R3 R4 R5 R6 R8 R9)
        for (int i = 0; i < 4000; i++) begin
            rd_en = ($urandom % 3) == 0;
            rd_addr = 3'($urandom);
            wr_en = ($urandom % 8) == 0;
            wr_addr = 3'($urandom);
            wr_data = 8'($urandom);
            top_evt = (($urandom % 4) == 0) ? 5'($urandom) : 5'h00;
            spc_evt = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            sts_evt = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 16) == 0) line_cond = 8'($urandom);
            step("R8 random");
        end
        idle();
        step("R9 random end");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule